// File: doc/BRIEF.md
# Pipelined Memory-Mapped Word Slave

This block is a small word-addressed register array that sits behind a pipelined memory-mapped request port. A master presents one request per cycle: a read strobe or a write strobe with an address, and for writes a data word and per-byte lane enables. A request is taken on a clock edge only if the slave is not stalling. Read data returns after a fixed pipeline latency on its own valid strobe. Each write is acknowledged on a separate done strobe. Both response kinds carry a two-bit status code.

Read responses always return after exactly `RD_LAT` cycles and take priority for the shared status code, so they never wait. Write acknowledgements wait in a first-in first-out queue and leave in acceptance order whenever no read response holds the cycle. The slave counts the reads and writes it has taken but not yet answered. It raises its stall output while either count sits at `MAX_OUT`, so a master that holds its request during a stall can never overrun the response path. An address past the end of the array is answered with the error code. A lock input is part of the port but has no effect.

Top module: `pms_slave`

## Requirements
- R1: In the first cycle after reset, `rd_valid`, `wr_done` and `wait_req` are all low.
- R2: A request is taken only at a rising edge where exactly one of `rd_en`/`wr_en` is high and `wait_req` is low. If both strobes are high together, nothing is taken: no response follows and the array does not change.
- R3: A taken in-range write updates only the byte lanes whose `byte_en` bit is set (bit i selects `wdata[8i+7:8i]`). Its acknowledgement carries status `2'b00`.
- R4: A taken in-range read returns the word as left by every write taken before it, with status `2'b00`.
- R5: An address at or above `WORDS` gets status `2'b11`. A write to it changes no word, and a read from it returns all-zero data.
- R6: A read response appears exactly `RD_LAT` cycles after the read is taken. A write acknowledgement appears one cycle after the write is taken at the earliest. Acknowledgements leave in the order the writes were taken.
- R7: `rd_valid` and `wr_done` are never high together. When both kinds are ready, the read goes first and the write waits for the next cycle without a read response.
- R8: `rd_valid` is high only while a taken read has no response yet. `wr_done` is high only while a taken write has no acknowledgement yet.
- R9: `wait_req` is high exactly when the unanswered reads or the unanswered writes number `MAX_OUT`. A request held through a stall is taken once, when the stall drops, and neither count ever exceeds `MAX_OUT`.
- R10: The `lock` input has no effect on any output or on the array contents.
- R11: While neither `rd_valid` nor `wr_done` is high, `rdata` is zero and `resp` is `2'b00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request strobe |
| wr_en | input | 1 | Write request strobe |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Write data |
| byte_en | input | DATA_W/8 | Byte lane enables for writes |
| lock | input | 1 | Lock indication from the master, ignored |
| wait_req | output | 1 | Stall: the request present is not taken |
| rd_valid | output | 1 | Read response strobe |
| rdata | output | DATA_W | Read response data |
| wr_done | output | 1 | Write acknowledgement strobe |
| resp | output | 2 | Status of the response shown: 00 ok, 11 error |

## Verification
Two conditions are hard to reach from the ports: a write acknowledgement that is ready in the same cycle as a read response, and the stall. Only one request is taken per cycle and writes answer in one cycle, so the write queue fills only when reads hold the response cycle. The bench therefore builds the slave with a read latency longer than the outstanding limit. It then issues back-to-back reads followed by writes, so reads pile up in the pipeline and `wait_req` rises, and it issues a read, an idle cycle and then writes, so a write becomes ready in the cycle the read returns. A long random mix of reads, writes, out-of-range addresses and lock values follows, checked on every clock against a queue-based model.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [1:0] {
      RESP_OK  = 2'b00,
      RESP_ERR = 2'b11
   } pms_resp_e;
endpackage

// File: rtl/pms_store.sv
module pms_store #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 16,
   parameter int IDX_W  = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] be,
   input  logic [IDX_W-1:0]    ridx,
   output logic [DATA_W-1:0]   rdata
);
   localparam int LANES = DATA_W / 8;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] cells [WORDS];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '0;
         end else if (we && be[l]) begin
            cells[widx] <= wdata[l*8 +: 8];
         end
      end
      assign rdata[l*8 +: 8] = cells[ridx];
   end
endmodule

// File: rtl/pms_rd_pipe.sv
module pms_rd_pipe #(
   parameter int DATA_W = 32,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_v,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        in_resp,
   output logic              out_v,
   output logic [DATA_W-1:0] out_data,
   output logic [1:0]        out_resp
);
   logic [RD_LAT-1:0] stg_v;
   logic [DATA_W-1:0] stg_d [RD_LAT];
   logic [1:0]        stg_r [RD_LAT];

   for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) stg_v[0] <= 1'b0;
            else     stg_v[0] <= in_v;
         end
         always_ff @(posedge clk) begin
            stg_d[0] <= in_data;
            stg_r[0] <= in_resp;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst) stg_v[s] <= 1'b0;
            else     stg_v[s] <= stg_v[s-1];
         end
         always_ff @(posedge clk) begin
            stg_d[s] <= stg_d[s-1];
            stg_r[s] <= stg_r[s-1];
         end
      end
   end

   assign out_v    = stg_v[RD_LAT-1];
   assign out_data = stg_d[RD_LAT-1];
   assign out_resp = stg_r[RD_LAT-1];
endmodule

// File: rtl/pms_fifo.sv
module pms_fifo #(
   parameter int W     = 2,
   parameter int DEPTH = 4,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [CW-1:0] count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     slots [DEPTH];
   logic [PTR_W-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) slots[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
         if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout  = slots[rp];
   assign empty = (count == '0);
endmodule

// File: rtl/pms_slave.sv
module pms_slave
   import pms_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6,
   parameter int WORDS   = 16,
   parameter int RD_LAT  = 2,
   parameter int MAX_OUT = 62,
   parameter int CNT_W   = 6
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] byte_en,
   input  logic                lock,
   output logic                wait_req,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rdata,
   output logic                wr_done,
   output logic [1:0]          resp
);
   localparam int IDX_W = $clog2(WORDS);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a positive multiple of 8");
   end
   if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for WORDS");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (MAX_OUT < 1 || MAX_OUT >= (1 << CNT_W) - 1) begin : g_bad_max
      $error("MAX_OUT must lie between 1 and 2**CNT_W-2");
   end

   logic              unused_lock;
   logic              in_range;
   logic              take_rd, take_wr;
   logic [CNT_W-1:0]  rd_owed, wr_owed;
   logic [DATA_W-1:0] cell_word;
   logic [1:0]        req_code;
   logic              pipe_v;
   logic [DATA_W-1:0] pipe_d;
   logic [1:0]        pipe_r;
   logic [1:0]        ack_code;
   logic              ack_empty;

   assign unused_lock = lock;

   if (ADDR_W > IDX_W) begin : g_range_chk
      assign in_range = ~|addr[ADDR_W-1:IDX_W];
   end else begin : g_range_full
      assign in_range = 1'b1;
   end

   assign wait_req = (rd_owed >= LIMIT) || (wr_owed >= LIMIT);
   assign take_rd  = rd_en & ~wr_en & ~wait_req;
   assign take_wr  = wr_en & ~rd_en & ~wait_req;
   assign req_code = in_range ? RESP_OK : RESP_ERR;

   pms_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (take_wr & in_range),
      .widx  (addr[IDX_W-1:0]),
      .wdata (wdata),
      .be    (byte_en),
      .ridx  (addr[IDX_W-1:0]),
      .rdata (cell_word)
   );

   pms_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .in_v     (take_rd),
      .in_data  (in_range ? cell_word : '0),
      .in_resp  (req_code),
      .out_v    (pipe_v),
      .out_data (pipe_d),
      .out_resp (pipe_r)
   );

   pms_fifo #(.W(2), .DEPTH(MAX_OUT), .CW(CNT_W)) u_ackq (
      .clk   (clk),
      .rst   (rst),
      .push  (take_wr),
      .din   (req_code),
      .pop   (wr_done),
      .dout  (ack_code),
      .empty (ack_empty),
      .count (wr_owed)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_owed <= '0;
      end else begin
         case ({take_rd, pipe_v})
            2'b10:   rd_owed <= rd_owed + 1'b1;
            2'b01:   rd_owed <= rd_owed - 1'b1;
            default: rd_owed <= rd_owed;
         endcase
      end
   end

   assign rd_valid = pipe_v;
   assign wr_done  = ~ack_empty & ~pipe_v;
   assign rdata    = pipe_v ? pipe_d : '0;
   assign resp     = pipe_v ? pipe_r : (wr_done ? ack_code : RESP_OK);
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
   parameter int DATA_W  = 32,
   parameter int MAX_OUT = 62,
   parameter int CNT_W   = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_en,
   input logic              wr_en,
   input logic              wait_req,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rdata,
   input logic              wr_done,
   input logic [1:0]        resp
);
   localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(MAX_OUT);

   logic [CNT_W:0] rd_seen, wr_seen;
   logic           got_rd, got_wr;

   assign got_rd = rd_en & ~wr_en & ~wait_req;
   assign got_wr = wr_en & ~rd_en & ~wait_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_seen <= '0;
         wr_seen <= '0;
      end else begin
         rd_seen <= rd_seen + {{CNT_W{1'b0}}, got_rd} - {{CNT_W{1'b0}}, rd_valid};
         wr_seen <= wr_seen + {{CNT_W{1'b0}}, got_wr} - {{CNT_W{1'b0}}, wr_done};
      end
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk) rst |=> (!rd_valid && !wr_done));
   // R7
   one_resp_chk: assert property (@(posedge clk) disable iff (rst) !(rd_valid && wr_done));
   // R8
   rd_owed_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> (rd_seen != '0));
   // R8
   wr_owed_chk: assert property (@(posedge clk) disable iff (rst) wr_done |-> (wr_seen != '0));
   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst) (rd_seen <= LIMIT) && (wr_seen <= LIMIT));
   // R9
   stall_cause_chk: assert property (@(posedge clk) disable iff (rst) wait_req |-> ((rd_seen >= LIMIT) || (wr_seen >= LIMIT)));
   // R5
   resp_code_chk: assert property (@(posedge clk) disable iff (rst) (rd_valid || wr_done) |-> (resp == 2'b00 || resp == 2'b11));
   // R6
   wr_ready_chk: assert property (@(posedge clk) disable iff (rst) (got_wr && wr_seen == '0) |=> (wr_done || rd_valid));
   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst) (!rd_valid && !wr_done) |-> (resp == 2'b00 && rdata == '0));
endmodule

bind pms_slave pms_checker #(.DATA_W(DATA_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .wait_req (wait_req),
   .rd_valid (rd_valid),
   .rdata    (rdata),
   .wr_done  (wr_done),
   .resp     (resp)
);

// File: tb/sim_pms_slave.sv
module sim_pms_slave;
   localparam int PERIOD  = 10;
   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 4;
   localparam int WORDS   = 8;
   localparam int RD_LAT  = 3;
   localparam int MAX_OUT = 2;
   localparam int CNT_W   = 6;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              rd_en = 1'b0, wr_en = 1'b0, lock = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0;
   logic [3:0]        byte_en = '0;
   logic              wait_req, rd_valid, wr_done;
   logic [31:0]       rdata;
   logic [1:0]        resp;

   always #(PERIOD/2) clk = ~clk;

   pms_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS), .RD_LAT(RD_LAT),
               .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .byte_en(byte_en), .lock(lock), .wait_req(wait_req),
      .rd_valid(rd_valid), .rdata(rdata), .wr_done(wr_done), .resp(resp)
   );

   // behavioural reference
   logic [31:0] m_mem [WORDS];
   int          r_due[$];
   logic [31:0] r_dat[$];
   logic [1:0]  r_rsp[$];
   string       r_tag[$];
   logic [1:0]  w_rsp[$];
   string       w_tag[$];
   int          cyc = 0;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic step(bit r, bit w, logic [ADDR_W-1:0] a, logic [31:0] d,
                       logic [3:0] b, bit lk, string tag, output bit took);
      bit          e_wait, e_rdv, e_wrv, inr;
      logic [31:0] e_dat;
      logic [1:0]  e_rsp;
      @(negedge clk);
      rd_en = r; wr_en = w; addr = a; wdata = d; byte_en = b; lock = lk;
      #1;
      e_wait = (r_due.size() >= MAX_OUT) || (w_rsp.size() >= MAX_OUT);
      e_rdv  = (r_due.size() > 0) && (r_due[0] == cyc);
      e_wrv  = !e_rdv && (w_rsp.size() > 0);
      e_dat  = e_rdv ? r_dat[0] : 32'h0;
      e_rsp  = e_rdv ? r_rsp[0] : (e_wrv ? w_rsp[0] : 2'b00);
      chk(wait_req == e_wait, "R9", "wait_req", 32'(wait_req), 32'(e_wait));
      chk(rd_valid == e_rdv, e_rdv ? "R6" : "R8", "rd_valid", 32'(rd_valid), 32'(e_rdv));
      chk(wr_done == e_wrv, e_rdv ? "R7" : (e_wrv ? "R6" : "R8"), "wr_done", 32'(wr_done), 32'(e_wrv));
      chk(rdata == e_dat, e_rdv ? r_tag[0] : "R11", "rdata", rdata, e_dat);
      chk(resp == e_rsp, e_rdv ? r_tag[0] : (e_wrv ? w_tag[0] : "R11"), "resp", 32'(resp), 32'(e_rsp));
      if (e_rdv) begin
         void'(r_due.pop_front()); void'(r_dat.pop_front());
         void'(r_rsp.pop_front()); void'(r_tag.pop_front());
      end else if (e_wrv) begin
         void'(w_rsp.pop_front()); void'(w_tag.pop_front());
      end
      took = (r ^ w) && !e_wait;
      inr  = (a < WORDS);
      if (took && r) begin
         r_due.push_back(cyc + RD_LAT);
         r_dat.push_back(inr ? m_mem[a[2:0]] : 32'h0);
         r_rsp.push_back(inr ? 2'b00 : 2'b11);
         r_tag.push_back(tag);
      end
      if (took && w) begin
         if (inr)
            for (int l = 0; l < 4; l++)
               if (b[l]) m_mem[a[2:0]][l*8 +: 8] = d[l*8 +: 8];
         w_rsp.push_back(inr ? 2'b00 : 2'b11);
         w_tag.push_back(tag);
      end
      cyc++;
   endtask

   task automatic idle(int n);
      bit t;
      for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 0, "R8", t);
   endtask

   // master holds the request until it is taken
   task automatic issue(bit r, logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] b, bit lk, string tag);
      bit t = 0;
      for (int i = 0; i < 50 && !t; i++) step(r, !r, a, d, b, lk, tag, t);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      bit t;
      for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: first cycle out of reset
      @(posedge clk); #1;
      chk(!rd_valid && !wr_done && !wait_req, "R1", "valids/stall", {rd_valid, wr_done, wait_req}, 0);
      chk(resp == 2'b00 && rdata == '0, "R1", "idle outputs", rdata | 32'(resp), 0);
      idle(2);

      // R3 / R4: full write, then read back
      issue(0, 4'd1, 32'hA1B2C3D4, 4'hF, 0, "R3");
      issue(1, 4'd1, '0, '0, 0, "R4");
      idle(4);
      // R3: partial lanes
      issue(0, 4'd1, 32'h11223344, 4'b0101, 0, "R3");
      issue(0, 4'd2, 32'hDEADBEEF, 4'b1000, 0, "R3");
      issue(1, 4'd1, '0, '0, 0, "R3");
      issue(1, 4'd2, '0, '0, 0, "R3");
      idle(5);

      // R9: back-to-back reads pile up and stall
      for (int i = 0; i < 6; i++) issue(1, 4'(i), '0, '0, 0, "R9");
      idle(5);
      // R7: read returns in the cycle a write is ready
      issue(1, 4'd1, '0, '0, 0, "R7");
      idle(1);
      issue(0, 4'd3, 32'h0BADF00D, 4'hF, 0, "R7");
      issue(0, 4'd4, 32'h12345678, 4'hF, 0, "R7");
      issue(1, 4'd3, '0, '0, 0, "R7");
      issue(0, 4'd5, 32'h55AA55AA, 4'hF, 0, "R9");
      issue(0, 4'd6, 32'h66666666, 4'hF, 0, "R9");
      idle(6);

      // R5: out of range, then confirm aliased word untouched
      issue(0, 4'd9, 32'hFFFFFFFF, 4'hF, 0, "R5");
      issue(1, 4'd15, '0, '0, 0, "R5");
      issue(1, 4'd1, '0, '0, 0, "R5");
      idle(5);

      // R2: both strobes high together is not taken
      step(1, 1, 4'd1, 32'h99999999, 4'hF, 0, "R2", t);
      chk(!t, "R2", "model took both", 32'(t), 0);
      idle(3);
      issue(1, 4'd1, '0, '0, 0, "R2");
      idle(4);

      // R10: lock has no effect
      issue(0, 4'd7, 32'hC0FFEE00, 4'hF, 1, "R10");
      issue(1, 4'd7, '0, '0, 1, "R10");
      idle(4);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned k = $urandom % 5;
         logic [ADDR_W-1:0] a = ADDR_W'($urandom);
         string tg = (a >= WORDS) ? "R5" : ((k == 1) ? "R4" : "R3");
         if (k == 0) idle(1);
         else if (k == 1 || k == 2) issue(1, a, '0, '0, 1'($urandom), tg);
         else issue(0, a, $urandom, 4'($urandom), 1'($urandom), tg);
      end
      idle(10);
      chk(r_due.size() == 0 && w_rsp.size() == 0, "R6", "drained",
          32'(r_due.size() + w_rsp.size()), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule